// File: doc/BRIEF.md
# Memory Init and Pattern Test Sequencer

This engine sweeps an attached memory one 64-byte line at a time, issuing every line as sixteen consecutive 32-bit word accesses on a request/ready port. It has two modes of operation.

In fill mode it makes a single pass that writes zero to every word, so that the check bits of an error-correcting memory start out consistent. In check mode it runs a fixed schedule of four passes, in this order:

1. write a constant pattern,
2. read the words back and compare them against that pattern,
3. write the bitwise inverse of the pattern,
4. read back and compare against the inverse.

Mismatches are folded into sticky per-byte-lane error bits. A read pass that leaves any error bit set ends the run early.

Software starts a run with a one-cycle `start` pulse, giving a mode and a memory size in bytes. The size is assumed to be a non-zero multiple of 64. While the run is in progress `busy` stays high. When the run completes, `busy` falls and `done` pulses for one cycle. `err_status` holds the outcome until the next run is started.

Top module: `memseq_engine`

## Requirements
- R1: With `mode` = 2'b01 (fill), one write-only pass is made. It writes 32'h0000_0000 to word addresses 0 up to 16*(mem_bytes/64)-1, in ascending order.
- R2: With `mode` = 2'b10 (check), four passes are made in the order write, read, write, read. Each pass covers word addresses 0 up to 16*(mem_bytes/64)-1 in ascending order.
- R3: The first write pass stores 32'h5AA5_5AA5, and the first read pass compares against that value. The second write pass stores 32'hA55A_A55A, and the second read pass compares against that value.
- R4: Word address = line*16 + word-in-line. The last line swept is mem_bytes/64 - 1, and no address beyond it is issued.
- R5: `err_status` is cleared whenever a run is started from idle, whatever the mode.
- R6: For a valid mode, `err_status[i]` (i = 0..3) is set when any compared read mismatches in bits [8i+7:8i]. These bits stay set for the rest of the run, and bits 31:4 remain zero.
- R7: When a read pass ends with any error bit set, the remaining passes are skipped and the run completes.
- R8: `busy` is high from the cycle after an accepted `start` until the run completes. `mem_req` is only ever high while `busy` is high.
- R9: `done` is a single-cycle pulse, raised in the cycle in which `busy` falls.
- R10: For `mode` 2'b00 or 2'b11, no memory access is made and `busy` stays low. In the cycle after `start`, `done` pulses and `err_status` becomes 32'hFFFF_FFFF.
- R11: A request that is not accepted (`mem_ready` low) stays asserted with unchanged address, direction and write data until it is accepted.
- R12: A `start` pulse that arrives while `busy` is high is ignored. The run in progress carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request, taken only while idle |
| mode | input | 2 | 2'b01 fill, 2'b10 check, other values unsupported |
| mem_bytes | input | SIZE_W (20) | Memory size in bytes, a multiple of 64 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| err_status | output | DATA_W (32) | Sticky lane error bits, or all ones for an unsupported mode |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W (18) | Word address |
| mem_wdata | output | DATA_W (32) | Write data |
| mem_ready | input | 1 | Request accepted this cycle; for reads, `mem_rdata` is valid |
| mem_rdata | input | DATA_W (32) | Read data |

## Verification
Two things can happen in the same clock edge. When a corrupted word is the very last word of a read pass, its lane bits must be recorded, and the early-end decision must be taken, in that one edge. The decision therefore has to see the freshly found miss as well as the bits already stored.

The bench provokes this by flipping bits of the final word of the range, on reads only. The scoreboard then expects exactly two passes of traffic, the correct lane bits, and `done` with no trailing accesses. A second run places the fault early in the range, which separates this case from an ordinary early miss.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_FILL  = 2'b01,
    MODE_CHECK = 2'b10,
    MODE_RSVD  = 2'b11
  } run_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Bit 0 of the pass index selects read, bit 1 selects the inverted pattern.
  function automatic logic pass_reads(input logic [1:0] pass_idx);
    return pass_idx[0];
  endfunction

  function automatic logic pass_inverts(input logic [1:0] pass_idx);
    return pass_idx[1];
  endfunction
endpackage

// File: rtl/memseq_walker.sv
module memseq_walker #(
  parameter int LINE_W = 14,
  parameter int WORD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clear,
  input  logic                     step,
  input  logic [LINE_W-1:0]        last_line,
  output logic [LINE_W+WORD_W-1:0] addr,
  output logic                     at_end
);
  logic [LINE_W-1:0] line_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      line_q <= '0;
      word_q <= '0;
    end else if (step) begin
      word_q <= word_q + 1'b1;
      if (&word_q) line_q <= line_q + 1'b1;
    end
  end

  assign addr   = {line_q, word_q};
  assign at_end = (&word_q) && (line_q == last_line);

  // Sweep never steps past the final line of the range.
  assert_line_bound_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> (line_q <= last_line));
endmodule

// File: rtl/memseq_lane_cmp.sv
module memseq_lane_cmp #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8
) (
  input  logic [DATA_W-1:0] expect_word,
  input  logic [DATA_W-1:0] actual_word,
  output logic [LANES-1:0]  lane_miss
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_miss[g] = (expect_word[g*8 +: 8] != actual_word[g*8 +: 8]);
  end
endmodule

// File: rtl/memseq_engine.sv
module memseq_engine
  import memseq_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          SIZE_W   = 20,
  parameter logic [31:0] BASE_PAT = 32'h5AA5_5AA5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic [SIZE_W-1:0]     mem_bytes,
  output logic                  busy,
  output logic                  done,
  output logic [DATA_W-1:0]     err_status,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [SIZE_W-6+$clog2(64/(DATA_W/8))-1:0] mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_ready,
  input  logic [DATA_W-1:0]     mem_rdata
);
  localparam int LANES   = DATA_W / 8;
  localparam int WPL     = 64 / LANES;
  localparam int WORD_W  = $clog2(WPL);
  localparam int LINE_W  = SIZE_W - 6;
  localparam int ADDR_W  = LINE_W + WORD_W;

  seq_state_e        state_q;
  run_mode_e         mode_q;
  logic [1:0]        pass_q;
  logic [LINE_W-1:0] last_line_q;
  logic [DATA_W-1:0] err_q;
  logic              done_q;

  logic              launch, mode_ok, accept, at_end, is_read, last_pass;
  logic              walk_clear;
  logic [LANES-1:0]  lane_miss;
  logic [DATA_W-1:0] exp_word, err_next;
  logic [SIZE_W-1:0] last_full;
  logic [ADDR_W-1:0] walk_addr;

  assign launch    = (state_q == ST_IDLE) && start;
  assign mode_ok   = (run_mode_e'(mode) == MODE_FILL) || (run_mode_e'(mode) == MODE_CHECK);
  assign accept    = (state_q == ST_RUN) && mem_ready;
  assign is_read   = (mode_q == MODE_CHECK) && pass_reads(pass_q);
  assign last_pass = (mode_q == MODE_FILL) || (pass_q == 2'd3);
  assign last_full = (mem_bytes >> 6) - 1'b1;

  always_comb begin
    if (mode_q == MODE_FILL)        exp_word = '0;
    else if (pass_inverts(pass_q))  exp_word = ~DATA_W'(BASE_PAT);
    else                            exp_word = DATA_W'(BASE_PAT);
  end

  assign err_next   = err_q | {{(DATA_W-LANES){1'b0}}, lane_miss};
  assign walk_clear = launch || (accept && at_end);

  memseq_walker #(.LINE_W(LINE_W), .WORD_W(WORD_W)) walk_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (walk_clear),
    .step      (accept),
    .last_line (last_line_q),
    .addr      (walk_addr),
    .at_end    (at_end)
  );

  memseq_lane_cmp #(.DATA_W(DATA_W), .LANES(LANES)) cmp_i (
    .expect_word (exp_word),
    .actual_word (mem_rdata),
    .lane_miss   (lane_miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_FILL;
      pass_q      <= '0;
      last_line_q <= '0;
      err_q       <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        if (mode_ok) begin
          err_q       <= '0;
          state_q     <= ST_RUN;
          mode_q      <= run_mode_e'(mode);
          pass_q      <= '0;
          last_line_q <= last_full[LINE_W-1:0];
        end else begin
          err_q  <= '1;
          done_q <= 1'b1;
        end
      end else if (accept) begin
        if (is_read) err_q <= err_next;
        if (at_end) begin
          if (last_pass || (is_read && (err_next != '0))) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            pass_q <= pass_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy       = (state_q == ST_RUN);
  assign done       = done_q;
  assign err_status = err_q;
  assign mem_req    = (state_q == ST_RUN);
  assign mem_we     = !is_read;
  assign mem_addr   = walk_addr;
  assign mem_wdata  = exp_word;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_on_fall_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    busy |=> ((err_status & $past(err_status)) == $past(err_status)));

  assert_bad_mode_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (mode == 2'b00 || mode == 2'b11)) |=> (done && !busy && (&err_status)));
endmodule

// File: tb/memseq_engine_tb_top.sv
module memseq_engine_tb_top;
  localparam int DW = 32;
  localparam int SW = 20;
  localparam int AW = 18;
  localparam logic [31:0] PAT  = 32'h5AA5_5AA5;
  localparam logic [31:0] IPAT = 32'hA55A_A55A;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [SW-1:0] mem_bytes = '0;
  logic          busy, done, mem_req, mem_we;
  logic [DW-1:0] err_status, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ready = 1'b0;

  memseq_engine #(.DATA_W(DW), .SIZE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .mem_bytes(mem_bytes),
    .busy(busy), .done(done), .err_status(err_status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [31:0]   data;
  } xact_t;
  xact_t exp_q[$];

  // Memory model with read-side fault injection.
  logic [31:0]   mem [0:1023];
  logic [AW-1:0] fault_addr = '0;
  logic [31:0]   fault_mask = '0;
  assign mem_rdata = mem[mem_addr[9:0]] ^ ((mem_addr == fault_addr) ? fault_mask : 32'h0);
  always @(posedge clk) if (mem_req && mem_ready && mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  int rdy_cnt = 0;
  always @(negedge clk) begin
    rdy_cnt = rdy_cnt + 1;
    mem_ready = (rdy_cnt % 3) != 0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc_total, 150000);
      finish_run();
    end
  end

  // Monitor: compare accepted accesses against the scoreboard queue.
  bit            stalled = 0;
  logic [AW-1:0] stall_addr;
  always begin
    @(negedge clk);
    #5;
    if (!rst) begin
      if (mem_req && !busy) chk(0, "R8", "request while idle", 32'(mem_req), 32'h0);
      if (stalled) chk(mem_req && mem_addr == stall_addr, "R11", "held address",
                       32'(mem_addr), 32'(stall_addr));
      stalled    = mem_req && !mem_ready;
      stall_addr = mem_addr;
      if (mem_req && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4", "unexpected access", 32'(mem_addr), 32'h0);
        end else begin
          xact_t e;
          e = exp_q.pop_front();
          chk(mem_we == e.we, "R2", "direction", 32'(mem_we), 32'(e.we));
          chk(mem_addr == e.addr, "R4", "word address", 32'(mem_addr), 32'(e.addr));
          if (e.we) chk(mem_wdata == e.data, "R3", "write data", mem_wdata, e.data);
        end
      end
    end
  end

  function automatic logic [31:0] lanes_of(input logic [31:0] m);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (m[8*i +: 8] != 8'h0) r[i] = 1'b1;
    return r;
  endfunction

  task automatic do_run(input logic [1:0] md, input int bytes, input logic [AW-1:0] faddr,
                        input logic [31:0] fmask, input int poke_at, input string tag);
    int words;
    int cyc;
    bit valid;
    logic [31:0] exp_err;
    fault_addr = faddr;
    fault_mask = fmask;
    valid = (md == 2'b01) || (md == 2'b10);
    words = (bytes / 64) * 16;
    exp_err = valid ? 32'h0 : 32'hFFFF_FFFF;
    if (md == 2'b01) begin
      for (int w = 0; w < words; w++) exp_q.push_back('{1'b1, AW'(w), 32'h0});
    end else if (md == 2'b10) begin
      for (int p = 0; p < 4; p++) begin
        for (int w = 0; w < words; w++)
          exp_q.push_back('{(p % 2) == 0, AW'(w), (p >= 2) ? IPAT : PAT});
        if ((p % 2) == 1 && fmask != 0 && int'(faddr) < words) begin
          exp_err = lanes_of(fmask);
          break;
        end
      end
    end
    @(negedge clk);
    start = 1'b1; mode = md; mem_bytes = SW'(bytes);
    @(negedge clk);
    start = 1'b0;
    if (!valid) begin
      chk(done && !busy, {"R10 ", tag}, "done at once, busy low", {30'h0, done, busy}, 32'h2);
      chk(err_status == 32'hFFFF_FFFF, {"R10 ", tag}, "error word", err_status, 32'hFFFF_FFFF);
      @(negedge clk);
      chk(!done, {"R9 ", tag}, "done width", 32'(done), 32'h0);
      chk(exp_q.size() == 0 && !busy, {"R10 ", tag}, "no access", 32'(exp_q.size()), 32'h0);
      return;
    end
    chk(busy && !done, {"R8 ", tag}, "busy after start", {30'h0, done, busy}, 32'h1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (!busy) chk(0, {"R8 ", tag}, "busy dropped early", 32'(busy), 32'h1);
      if (cyc == poke_at) begin
        start = 1'b1; mode = 2'b01; mem_bytes = SW'(64);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done && !busy, {"R9 ", tag}, "done with busy low", {30'h0, done, busy}, 32'h2);
    chk(err_status == exp_err, {"R6 R7 ", tag}, "error status", err_status, exp_err);
    chk(exp_q.size() == 0, {"R1 R2 ", tag}, "accesses left", 32'(exp_q.size()), 32'h0);
    @(negedge clk);
    chk(!done, {"R9 ", tag}, "done width", 32'(done), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 + i;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R8", "reset outputs", {29'h0, busy, done, mem_req}, 32'h0);
    chk(err_status == 32'h0, "R5", "reset error", err_status, 32'h0);

    do_run(2'b01, 256, '0, 32'h0, -1, "R1 fill");
    do_run(2'b10, 256, '0, 32'h0, -1, "R2 R3 clean check");
    do_run(2'b10, 256, AW'(63), 32'h00FF_0000, -1, "R7 last word miss");
    do_run(2'b10, 128, AW'(5), 32'h0100_0001, -1, "R5 R6 two lanes");
    do_run(2'b11, 256, '0, 32'h0, -1, "R10 mode3");
    do_run(2'b00, 256, '0, 32'h0, -1, "R10 mode0");
    do_run(2'b10, 64, '0, 32'h0, -1, "R5 single line");
    do_run(2'b01, 192, '0, 32'h0, 10, "R12 start ignored");
    do_run(2'b10, 256, AW'(64), 32'hFFFF_FFFF, -1, "R4 fault outside range");
    finish_run();
  end
endmodule